// File: doc/BRIEF.md
# Nibble-Coded Register Machine Core

This block is a small multicycle processor. It has sixteen 8-bit general registers, an 8-bit program counter, a 16-bit instruction register and a 256-byte internal memory that holds both program and data. Every instruction is one 16-bit word made of four hex digits. The top digit selects the operation. The other three digits are either a register number followed by an 8-bit address or constant, or three register numbers.

A host fills the memory through a write port while the core is stopped. It then pulses `start`, and the core runs from address 0x00 until it reaches a halt instruction or an opcode it does not know. After that the host reads memory and registers back through two read ports. Each instruction passes through the same fixed sequence: two fetch cycles, a decode cycle that also gathers operands, an execute cycle and a result-store cycle. The core then goes back to fetch.

Top module: `nibble_cpu`

## Requirements
- R1: After reset `busy`, `halted` and `illegal` are 0, all sixteen registers read 0x00, and the program counter is 0x00.
- R2: An instruction is the two bytes at PC (bits 15:8) and PC+1 (bits 7:0). Execution starts at 0x00 and PC advances by 2 during fetch. Digit 15:12 is the opcode, 11:8 is R, 7:4 is S, 3:0 is T, and bits 7:0 form the address or constant XY.
- R3: Opcode 0x1 copies the memory byte at address XY into register R.
- R4: Opcode 0x2 writes the constant XY into register R.
- R5: Opcode 0x3 writes register R into memory at address XY.
- R6: Opcode 0x5 writes S+T into R as an 8-bit two's-complement sum that wraps modulo 256 (0x5C+0x5A=0xB6, 0xF0+0x20=0x10, 0xB6+0xB6=0x6C). No flag is kept.
- R7: Opcode 0xC stops the core. `halted` then stays 1 and `busy` stays 0 until reset, and `start` has no effect while halted.
- R8: Any opcode other than 0x1, 0x2, 0x3, 0x5 or 0xC sets `illegal`, stops the core the same way a halt does, and writes nothing. `illegal` stays 0 for a normal halt.
- R9: Counting the clock edge that samples `start` as edge 1, a program with n non-halting instructions followed by a halt or an illegal word raises `halted` after edge 5n+4.
- R10: `busy` is 1 from the start edge until the core stops. A host memory write is dropped while `busy` is 1 and accepted when it is 0, including after a halt.
- R11: `hostRdata` shows the memory byte at `hostAddr` and `hostRegRdata` shows the register selected by `hostRegSel`. Both reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins execution when the core is idle |
| hostWe | input | 1 | Host memory write enable |
| hostAddr | input | 8 | Host memory address for write and read |
| hostWdata | input | 8 | Host memory write data |
| hostRdata | output | 8 | Memory byte at hostAddr |
| hostRegSel | input | 4 | Register number for host read |
| hostRegRdata | output | 8 | Contents of the selected register |
| busy | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped (halt or illegal opcode) |
| illegal | output | 1 | Stop was caused by an unknown opcode |

## Verification
Each instruction result becomes visible exactly five edges after its own fetch began, and `halted` rises exactly 5n+4 edges after the start edge. The bench counts edges from the start edge and compares the edge where `halted` first appears with 5n+4, so a skipped or extra step shows up as a count error. It drives inputs on falling edges and samples one time unit after them. It reads stored bytes and registers only after the core has stopped, when they can no longer change. The host write that must be dropped is issued on the third edge of the run, and the same cell is read back after the halt.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int NIB_W   = 4;
  localparam int INSTR_W = 4 * NIB_W;
  localparam int REG_CNT = 1 << NIB_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  localparam logic [NIB_W-1:0] OP_LDM = 4'h1;
  localparam logic [NIB_W-1:0] OP_LDI = 4'h2;
  localparam logic [NIB_W-1:0] OP_STM = 4'h3;
  localparam logic [NIB_W-1:0] OP_ADD = 4'h5;
  localparam logic [NIB_W-1:0] OP_HLT = 4'hC;

  typedef struct packed {
    logic irHiLoad;
    logic irLoLoad;
    logic pcInc;
    logic opLoad;
    logic resLoad;
    logic regWrite;
    logic memWrite;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_DECODE,
    ST_EXEC,
    ST_WBACK,
    ST_HALT
  } state_e;
endpackage

// File: rtl/cpu_mem.sv
module cpu_mem
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddrCore,
  output logic [DATA_W-1:0] rDataCore,
  input  logic [ADDR_W-1:0] rAddrHost,
  output logic [DATA_W-1:0] rDataHost
);
  logic [DATA_W-1:0] cells [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
  end

  assign rDataCore = cells[rAddrCore];
  assign rDataHost = cells[rAddrHost];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NIB_W-1:0] opcode,
  output strobe_t          strobes,
  output logic             busy,
  output logic             halted,
  output logic             illegal
);
  state_e state, stateNext;
  logic   isLegal;
  logic   isHalt;
  logic   illegalQ;

  always_comb begin
    isLegal = (opcode == OP_LDM) || (opcode == OP_LDI) ||
              (opcode == OP_STM) || (opcode == OP_ADD);
    isHalt  = (opcode == OP_HLT);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (start) stateNext = ST_FETCH_HI;
      ST_FETCH_HI: stateNext = ST_FETCH_LO;
      ST_FETCH_LO: stateNext = ST_DECODE;
      ST_DECODE:   stateNext = isLegal ? ST_EXEC : ST_HALT;
      ST_EXEC:     stateNext = ST_WBACK;
      ST_WBACK:    stateNext = ST_FETCH_HI;
      ST_HALT:     stateNext = ST_HALT;
      default:     stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      illegalQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_DECODE && !isLegal && !isHalt) illegalQ <= 1'b1;
    end
  end

  always_comb begin
    strobes = '0;
    case (state)
      ST_FETCH_HI: begin
        strobes.irHiLoad = 1'b1;
        strobes.pcInc    = 1'b1;
      end
      ST_FETCH_LO: begin
        strobes.irLoLoad = 1'b1;
        strobes.pcInc    = 1'b1;
      end
      ST_DECODE:   strobes.opLoad  = isLegal;
      ST_EXEC:     strobes.resLoad = 1'b1;
      ST_WBACK: begin
        strobes.memWrite = (opcode == OP_STM);
        strobes.regWrite = (opcode != OP_STM);
      end
      default: strobes = '0;
    endcase
  end

  assign busy    = (state != ST_IDLE) && (state != ST_HALT);
  assign halted  = (state == ST_HALT);
  assign illegal = illegalQ;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !busy)); // R7

  AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted); // R8

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.irHiLoad, strobes.irLoLoad, strobes.opLoad,
              strobes.resLoad, strobes.regWrite, strobes.memWrite})); // R9

  AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(strobes.regWrite || strobes.memWrite)); // R8
endmodule

// File: rtl/cpu_dpath.sv
module cpu_dpath
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [NIB_W-1:0]  opcode,
  input  logic [NIB_W-1:0]  hostRegSel,
  output logic [DATA_W-1:0] hostRegRdata
);
  localparam int HALF_W = INSTR_W / 2;

  logic [ADDR_W-1:0]  pcQ;
  logic [INSTR_W-1:0] irQ;
  logic [DATA_W-1:0]  opAQ, opBQ, resQ;
  logic [NIB_W-1:0]   rIdx, sIdx, tIdx;
  logic [DATA_W-1:0]  xyField;
  logic [DATA_W-1:0]  regView [REG_CNT];

  assign opcode  = irQ[INSTR_W-1 -: NIB_W];
  assign rIdx    = irQ[3*NIB_W-1 -: NIB_W];
  assign sIdx    = irQ[2*NIB_W-1 -: NIB_W];
  assign tIdx    = irQ[NIB_W-1:0];
  assign xyField = irQ[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      irQ  <= '0;
      opAQ <= '0;
      opBQ <= '0;
      resQ <= '0;
    end else begin
      if (strobes.pcInc)    pcQ <= pcQ + ADDR_W'(1);
      if (strobes.irHiLoad) irQ[INSTR_W-1:HALF_W] <= memRdata;
      if (strobes.irLoLoad) irQ[HALF_W-1:0]       <= memRdata;
      if (strobes.opLoad) begin
        case (opcode)
          OP_LDM:  opAQ <= memRdata;
          OP_LDI:  opAQ <= xyField;
          default: opAQ <= regView[sIdx];
        endcase
        opBQ <= regView[tIdx];
      end
      if (strobes.resLoad) resQ <= (opcode == OP_ADD) ? (opAQ + opBQ) : opAQ;
    end
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strobes.regWrite && rIdx == NIB_W'(g)) q <= resQ;
    end
    assign regView[g] = q;
  end

  assign memAddr      = (strobes.irHiLoad || strobes.irLoLoad) ? pcQ : xyField;
  assign memWdata     = regView[rIdx];
  assign hostRegRdata = regView[hostRegSel];

  AST_PC_EVEN_AT_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.opLoad |-> (pcQ[0] == 1'b0)); // R2

  AST_IR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.irHiLoad || strobes.irLoLoad) |=> $stable(irQ)); // R2

  AST_REGWR_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regWrite |-> (opcode == OP_LDM || opcode == OP_LDI || opcode == OP_ADD)); // R4

  AST_STORE_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWrite |-> (opcode == OP_STM)); // R5
endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [NIB_W-1:0]  hostRegSel,
  output logic [DATA_W-1:0] hostRegRdata,
  output logic              busy,
  output logic              halted,
  output logic              illegal
);
  strobe_t           strobes;
  logic [NIB_W-1:0]  opcode;
  logic [ADDR_W-1:0] coreAddr;
  logic [DATA_W-1:0] coreRdata, coreWdata;
  logic              memWe;
  logic [ADDR_W-1:0] memWAddr;
  logic [DATA_W-1:0] memWData;

  cpu_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .strobes (strobes),
    .busy    (busy),
    .halted  (halted),
    .illegal (illegal)
  );

  cpu_dpath i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .memRdata     (coreRdata),
    .memAddr      (coreAddr),
    .memWdata     (coreWdata),
    .opcode       (opcode),
    .hostRegSel   (hostRegSel),
    .hostRegRdata (hostRegRdata)
  );

  always_comb begin
    if (busy) begin
      memWe    = strobes.memWrite;
      memWAddr = coreAddr;
      memWData = coreWdata;
    end else begin
      memWe    = hostWe;
      memWAddr = hostAddr;
      memWData = hostWdata;
    end
  end

  cpu_mem i_mem (
    .clk       (clk),
    .we        (memWe),
    .wAddr     (memWAddr),
    .wData     (memWData),
    .rAddrCore (coreAddr),
    .rDataCore (coreRdata),
    .rAddrHost (hostAddr),
    .rDataHost (hostRdata)
  );

  AST_START_BEGINS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !halted) |=> busy); // R10
endmodule

// File: tb/test_nibble_cpu.sv
module test_nibble_cpu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       hostWe = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [3:0] hostRegSel = '0;
  logic [7:0] hostRegRdata;
  logic       busy, halted, illegal;

  int vecCnt = 0;
  int missCnt = 0;
  bit doneFlag = 1'b0;

  bit         sbIsReg [$];
  logic [7:0] sbIdx   [$];
  logic [7:0] sbVal   [$];
  string      sbTag   [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_cpu i_nibble_cpu (
    .clk (clk), .rstN (rstN), .start (start),
    .hostWe (hostWe), .hostAddr (hostAddr), .hostWdata (hostWdata),
    .hostRdata (hostRdata), .hostRegSel (hostRegSel),
    .hostRegRdata (hostRegRdata), .busy (busy), .halted (halted),
    .illegal (illegal)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expectMem(input logic [7:0] a, input logic [7:0] v, input string tag);
    sbIsReg.push_back(1'b0); sbIdx.push_back(a); sbVal.push_back(v); sbTag.push_back(tag);
  endtask

  task automatic expectReg(input logic [3:0] r, input logic [7:0] v, input string tag);
    sbIsReg.push_back(1'b1); sbIdx.push_back({4'h0, r}); sbVal.push_back(v); sbTag.push_back(tag);
  endtask

  // monitor: pops each expected item and compares it with what the host ports show
  task automatic drainScoreboard();
    while (sbIdx.size() > 0) begin
      bit         isReg = sbIsReg.pop_front();
      logic [7:0] idx   = sbIdx.pop_front();
      logic [7:0] val   = sbVal.pop_front();
      string      tag   = sbTag.pop_front();
      @(negedge clk);
      if (isReg) hostRegSel = idx[3:0]; else hostAddr = idx;
      #1;
      if (isReg) check(tag, $sformatf("reg %0h", idx), hostRegRdata, val);
      else       check(tag, $sformatf("mem %h", idx), hostRdata, val);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic putWord(input logic [7:0] a, input logic [15:0] w);
    hostWrite(a, w[15:8]);
    hostWrite(a + 8'd1, w[7:0]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // R9: counts edges from the one that samples start until halted is seen
  task automatic runToHalt(input int expEdges, input bit poke, input string tag);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1;
    while (cnt < 500) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
      if (poke && cnt == 3) begin
        #1;
        check("R10", "busy while running", {7'd0, busy}, 8'h01);
        hostWe = 1'b1; hostAddr = 8'h80; hostWdata = 8'h55;
      end
      if (poke && cnt == 4) hostWe = 1'b0;
      if (halted) break;
    end
    hostWe = 1'b0;
    if (cnt >= 500) begin
      missCnt++;
      $display("FAIL %s run never halted: actual %0d expected %0d", tag, cnt, expEdges);
    end else begin
      vecCnt++;
      if (cnt != expEdges) begin
        missCnt++;
        $display("FAIL %s halt edge: actual %0d expected %0d", tag, cnt, expEdges);
      end
    end
  endtask

  initial begin
    doReset();
    #1;
    // R1: reset state
    check("R1", "busy", {7'd0, busy}, 8'h00);
    check("R1", "halted", {7'd0, halted}, 8'h00);
    check("R1", "illegal", {7'd0, illegal}, 8'h00);
    for (int r = 0; r < 16; r++) expectReg(4'(r), 8'h00, "R1");
    drainScoreboard();

    // main program; R2: two-byte words from 0x00 upward
    putWord(8'h00, 16'h156C); // r5 <= mem[6C]
    putWord(8'h02, 16'h166D); // r6 <= mem[6D]
    putWord(8'h04, 16'h5056); // r0 <= r5 + r6
    putWord(8'h06, 16'h306E); // mem[6E] <= r0
    putWord(8'h08, 16'h2AF0); // rA <= F0
    putWord(8'h0A, 16'h2B20); // rB <= 20
    putWord(8'h0C, 16'h5CAB); // rC <= rA + rB
    putWord(8'h0E, 16'h5D00); // rD <= r0 + r0
    putWord(8'h10, 16'h3C6F); // mem[6F] <= rC
    putWord(8'h12, 16'hC000); // halt
    hostWrite(8'h6C, 8'h5C);
    hostWrite(8'h6D, 8'h5A);
    hostWrite(8'h80, 8'h11);

    runToHalt(5*9 + 4, 1'b1, "R9");
    #1;
    check("R7", "halted after halt word", {7'd0, halted}, 8'h01);
    check("R8", "no illegal on halt", {7'd0, illegal}, 8'h00);
    check("R10", "busy after halt", {7'd0, busy}, 8'h00);
    expectReg(4'h5, 8'h5C, "R3");
    expectReg(4'h6, 8'h5A, "R3");
    expectReg(4'hA, 8'hF0, "R4");
    expectReg(4'hB, 8'h20, "R4");
    expectReg(4'h0, 8'hB6, "R6");
    expectReg(4'hC, 8'h10, "R6");
    expectReg(4'hD, 8'h6C, "R6");
    expectReg(4'h1, 8'h00, "R2");
    expectMem(8'h6E, 8'hB6, "R5");
    expectMem(8'h6F, 8'h10, "R5");
    expectMem(8'h6C, 8'h5C, "R11");
    expectMem(8'h80, 8'h11, "R10");
    drainScoreboard();

    hostWrite(8'h81, 8'h77);
    expectMem(8'h81, 8'h77, "R10");
    drainScoreboard();

    // R7: start while halted is ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) begin
      @(negedge clk); #1;
      check("R7", "stays halted", {6'd0, halted, busy}, 8'h02);
    end

    // R8: illegal word after one instruction
    doReset();
    #1;
    check("R1", "halted cleared", {7'd0, halted}, 8'h00);
    expectReg(4'h0, 8'h00, "R1");
    drainScoreboard();
    putWord(8'h00, 16'h2133);
    putWord(8'h02, 16'h7144);
    putWord(8'h04, 16'h2199);
    runToHalt(5*1 + 4, 1'b0, "R9");
    #1;
    check("R8", "illegal flag", {6'd0, illegal, halted}, 8'h03);
    expectReg(4'h1, 8'h33, "R8");
    drainScoreboard();

    // R8: opcode 6 at first word
    doReset();
    putWord(8'h00, 16'h6123);
    runToHalt(4, 1'b0, "R9");
    #1;
    check("R8", "opcode 6 illegal", {6'd0, illegal, halted}, 8'h03);
    expectReg(4'h1, 8'h00, "R8");
    drainScoreboard();

    // R7: bare halt
    doReset();
    putWord(8'h00, 16'hC000);
    runToHalt(4, 1'b0, "R9");
    #1;
    check("R7", "bare halt", {6'd0, illegal, halted}, 8'h01);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      missCnt++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end
endmodule